// File: doc/BRIEF.md
# Register-Controlled Serial Peripheral Master

This block is a serial peripheral interface master that software drives through a small bank of word-addressed registers. Software picks a target device and asserts its active-low select through the control register, sets the clock polarity, clock phase, word width (8 or 16 bits), half-period length and the bit order of each direction in the configuration register, and then writes one word to the data-out register. That write starts the transfer. When the last bit has been shifted, the cause register reads nonzero, `irq` goes high, and the received word can be read from the data-in register. Software acknowledges by writing zero to the cause register.

A separate tick generator sets the serial clock rate. It produces one enable pulse per half period. A two-bit sample-point code in the timing register can move MISO capture one core clock past the nominal sample edge. This helps when the slave's data arrives late at the fastest clock rate. The transfer sequencer has three states:
- **IDLE**: SCK follows the configured polarity. A start moves the sequencer to SHIFT.
- **SHIFT**: SCK toggles on every tick. The final edge moves the sequencer to FLUSH.
- **FLUSH**: The sequencer waits until any pending late capture has landed, reports completion and returns to IDLE.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the cause register (offset 0x10) reads 0, `irq` is low, all `cs_n` lines are high, SCK is low, the configuration register (0x04) reads 0, and the timing register (0x18) reads 0x40 (sample code 1 in bits [7:6]).
- R2: Control register (0x00) bits [4:2] hold a select index and bit 0 is an enable. While the enable is set, exactly `cs_n[index]` is low. While it is clear, every `cs_n` line is high.
- R3: A write to data out (0x08) while idle starts a word of 8 bits (configuration bit 5 clear) or 16 bits (bit 5 set). The transfer produces exactly twice that many SCK edges, and consecutive edges are spaced by configuration bits [3:0] plus one core clocks.
- R4: Configuration bit 11 sets the SCK idle level. Configuration bit 12 selects the phase. With bit 12 clear, the first MOSI bit is valid before the first edge and MISO is sampled on odd (leading) edges. With bit 12 set, MOSI changes on leading edges and MISO is sampled on even (trailing) edges.
- R5: Configuration bit 13 set transmits the data-out word LSB first. Clear transmits it MSB first.
- R6: Configuration bit 14 set places the first received bit in bit 0. Clear places it in the top bit of the word. This choice is independent of bit 13.
- R7: When a word completes, the cause register reads 1 and `irq` is high. Writing zero to the cause register clears both. Writing a nonzero value to it has no effect.
- R8: Data in (0x0C) holds the last received word, right-aligned and zero-extended to 32 bits.
- R9: With timing code 2 in bits [7:6], each MISO bit is captured one core clock after its nominal sample edge. Codes 0, 1 and 3 capture on the sample edge itself.
- R10: A write to data out while a transfer is in progress is ignored. It neither restarts nor extends the transfer and produces no second completion.
- R11: Whenever no transfer is running, SCK sits at the configured polarity level, including after a polarity change while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | High while the cause register is nonzero |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 8 | Active-low device selects |

## Verification
The hardest behaviour to observe from the ports is the late sample point. A well-behaved slave holds MISO steady for the whole half period, so nominal and delayed capture return the same word. To separate them, the bench slave presents one word (A) during each half period and then switches MISO to the corresponding bit of a second word (B) in the core clock right after every sample edge. Nominal capture then returns A and late capture returns B. Because the slave places bits according to the receive order, the same stimulus also exercises the receive bit order. The ignored mid-transfer write is checked by counting every SCK edge after completion and confirming that the count stops at twice the word length.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int HALF_DIV_W = 4;

    // register byte offsets
    localparam int OFF_CTL    = 'h00;
    localparam int OFF_CFG    = 'h04;
    localparam int OFF_TXD    = 'h08;
    localparam int OFF_RXD    = 'h0C;
    localparam int OFF_CAUSE  = 'h10;
    localparam int OFF_TIMING = 'h18;

    // field positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_SEL_LO    = 2;
    localparam int CFG_DIV_LO    = 0;
    localparam int CFG_WIDE_BIT  = 5;
    localparam int CFG_CPOL_BIT  = 11;
    localparam int CFG_CPHA_BIT  = 12;
    localparam int CFG_TXLSB_BIT = 13;
    localparam int CFG_RXLSB_BIT = 14;
    localparam int TIM_CODE_LO   = 6;

    localparam logic [1:0] CODE_DEFAULT = 2'd1;
    localparam logic [1:0] CODE_LATE    = 2'd2;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_SHIFT,
        XS_FLUSH
    } xfer_state_e;

    typedef struct packed {
        logic                  cpol;
        logic                  cpha;
        logic                  wide;
        logic                  tx_lsb;
        logic                  rx_lsb;
        logic                  late;
        logic [HALF_DIV_W-1:0] half_div;
    } xfer_cfg_t;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen
    import spi_rm_pkg::*;
#(
    parameter int DIV_W = HALF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // half period never overruns the programmed length
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(half_div)) |-> (cnt_q <= half_div));

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NUM_CS = 8,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] cs_n
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        assign cs_n[g] = !(en && (sel == SEL_W'(g)));
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_rm_pkg::*;
#(
    parameter int MAX_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  xfer_cfg_t             cfg_in,
    input  logic [MAX_BITS-1:0]   word_in,
    input  logic                  miso,
    input  logic                  tick,
    output logic                  run,
    output logic                  busy,
    output logic                  done,
    output logic [MAX_BITS-1:0]   rx_word,
    output logic                  sck,
    output logic                  mosi,
    output logic [HALF_DIV_W-1:0] half_div
);

    localparam int BIT_W = $clog2(MAX_BITS);
    localparam int CNT_W = $clog2(2 * MAX_BITS) + 1;

    xfer_state_e           state_q, state_d;
    xfer_cfg_t             cfg_q;
    logic [MAX_BITS-1:0]   word_q;
    logic [MAX_BITS-1:0]   rx_q;
    logic [CNT_W-1:0]      edge_cnt_q;
    logic [BIT_W-1:0]      tx_idx_q, rx_idx_q;
    logic                  late_pend_q;
    logic                  sck_q, mosi_q;

    logic [BIT_W-1:0]      nbits_m1, tx_pos, rx_pos, first_pos;
    logic [CNT_W-1:0]      last_edge, edge_nxt;
    logic                  sample_edge, final_edge, drive_edge;

    assign nbits_m1    = cfg_q.wide ? BIT_W'(MAX_BITS - 1) : BIT_W'(MAX_BITS / 2 - 1);
    assign last_edge   = cfg_q.wide ? CNT_W'(2 * MAX_BITS) : CNT_W'(MAX_BITS);
    assign edge_nxt    = edge_cnt_q + 1'b1;
    assign sample_edge = cfg_q.cpha ? !edge_nxt[0] : edge_nxt[0];
    assign final_edge  = (edge_nxt == last_edge);
    assign drive_edge  = !sample_edge && !final_edge;
    assign tx_pos      = cfg_q.tx_lsb ? tx_idx_q : (nbits_m1 - tx_idx_q);
    assign rx_pos      = cfg_q.rx_lsb ? rx_idx_q : (nbits_m1 - rx_idx_q);
    assign first_pos   = cfg_in.tx_lsb ? '0 :
                         (cfg_in.wide ? BIT_W'(MAX_BITS - 1) : BIT_W'(MAX_BITS / 2 - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, final edge, capture drained
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (start) state_d = XS_SHIFT;
            XS_SHIFT: if (tick && final_edge) state_d = XS_FLUSH;
            XS_FLUSH: if (!late_pend_q) state_d = XS_IDLE;
            default:  state_d = XS_IDLE;
        endcase
    end

    // datapath and serial outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            word_q      <= '0;
            rx_q        <= '0;
            edge_cnt_q  <= '0;
            tx_idx_q    <= '0;
            rx_idx_q    <= '0;
            late_pend_q <= 1'b0;
            sck_q       <= 1'b0;
            mosi_q      <= 1'b0;
        end else begin
            if (late_pend_q) begin
                rx_q[rx_pos] <= miso;
                rx_idx_q     <= rx_idx_q + 1'b1;
                late_pend_q  <= 1'b0;
            end
            unique case (state_q)
                XS_IDLE: begin
                    sck_q <= cfg_in.cpol;
                    if (start) begin
                        cfg_q       <= cfg_in;
                        word_q      <= word_in;
                        rx_q        <= '0;
                        edge_cnt_q  <= '0;
                        rx_idx_q    <= '0;
                        late_pend_q <= 1'b0;
                        if (!cfg_in.cpha) begin
                            mosi_q   <= word_in[first_pos];
                            tx_idx_q <= BIT_W'(1);
                        end else begin
                            tx_idx_q <= '0;
                        end
                    end
                end
                XS_SHIFT: begin
                    if (tick) begin
                        sck_q      <= ~sck_q;
                        edge_cnt_q <= edge_nxt;
                        if (sample_edge) begin
                            if (cfg_q.late) begin
                                late_pend_q <= 1'b1;
                            end else begin
                                rx_q[rx_pos] <= miso;
                                rx_idx_q     <= rx_idx_q + 1'b1;
                            end
                        end
                        if (drive_edge) begin
                            mosi_q   <= word_q[tx_pos];
                            tx_idx_q <= tx_idx_q + 1'b1;
                        end
                    end
                end
                XS_FLUSH: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign run      = (state_q == XS_SHIFT);
    assign busy     = (state_q != XS_IDLE);
    assign done     = (state_q == XS_FLUSH) && !late_pend_q;
    assign rx_word  = rx_q;
    assign sck      = sck_q;
    assign mosi     = mosi_q;
    assign half_div = cfg_q.half_div;

    assert_edge_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (edge_cnt_q == last_edge));

    assert_flush_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_FLUSH) |-> (sck_q == cfg_q.cpol));

    assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_IDLE && $past(state_q) == XS_IDLE && $stable(cfg_in.cpol))
        |-> (sck_q == cfg_in.cpol));

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int NUM_CS   = 8,
    parameter int MAX_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    localparam int SEL_W = $clog2(NUM_CS);

    logic                  ctl_en_q;
    logic [SEL_W-1:0]      ctl_sel_q;
    logic                  cpol_q, cpha_q, wide_q, txl_q, rxl_q;
    logic [HALF_DIV_W-1:0] div_q;
    logic [1:0]            tim_code_q;
    logic [MAX_BITS-1:0]   din_q;
    logic                  cause_q;

    logic wr_ctl, wr_cfg, wr_txd, wr_cause, wr_tim;
    logic start, run, busy, xfer_done, tick;
    logic [MAX_BITS-1:0]   rx_word;
    logic [HALF_DIV_W-1:0] half_div;
    xfer_cfg_t             cfg_live;

    assign wr_ctl   = reg_wr && (reg_addr == ADDR_W'(OFF_CTL));
    assign wr_cfg   = reg_wr && (reg_addr == ADDR_W'(OFF_CFG));
    assign wr_txd   = reg_wr && (reg_addr == ADDR_W'(OFF_TXD));
    assign wr_cause = reg_wr && (reg_addr == ADDR_W'(OFF_CAUSE));
    assign wr_tim   = reg_wr && (reg_addr == ADDR_W'(OFF_TIMING));
    assign start    = wr_txd && !busy;

    always_comb begin
        cfg_live.cpol     = cpol_q;
        cfg_live.cpha     = cpha_q;
        cfg_live.wide     = wide_q;
        cfg_live.tx_lsb   = txl_q;
        cfg_live.rx_lsb   = rxl_q;
        cfg_live.late     = (tim_code_q == CODE_LATE);
        cfg_live.half_div = div_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en_q   <= 1'b0;
            ctl_sel_q  <= '0;
            cpol_q     <= 1'b0;
            cpha_q     <= 1'b0;
            wide_q     <= 1'b0;
            txl_q      <= 1'b0;
            rxl_q      <= 1'b0;
            div_q      <= '0;
            tim_code_q <= CODE_DEFAULT;
            din_q      <= '0;
            cause_q    <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctl_en_q  <= reg_wdata[CTL_EN_BIT];
                ctl_sel_q <= reg_wdata[CTL_SEL_LO +: SEL_W];
            end
            if (wr_cfg) begin
                cpol_q <= reg_wdata[CFG_CPOL_BIT];
                cpha_q <= reg_wdata[CFG_CPHA_BIT];
                wide_q <= reg_wdata[CFG_WIDE_BIT];
                txl_q  <= reg_wdata[CFG_TXLSB_BIT];
                rxl_q  <= reg_wdata[CFG_RXLSB_BIT];
                div_q  <= reg_wdata[CFG_DIV_LO +: HALF_DIV_W];
            end
            if (wr_tim) begin
                tim_code_q <= reg_wdata[TIM_CODE_LO +: 2];
            end
            if (xfer_done) begin
                din_q   <= rx_word;
                cause_q <= 1'b1;
            end else if (wr_cause && (reg_wdata == '0)) begin
                cause_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_CTL): begin
                reg_rdata[CTL_EN_BIT]            = ctl_en_q;
                reg_rdata[CTL_SEL_LO +: SEL_W]   = ctl_sel_q;
            end
            ADDR_W'(OFF_CFG): begin
                reg_rdata[CFG_CPOL_BIT]              = cpol_q;
                reg_rdata[CFG_CPHA_BIT]              = cpha_q;
                reg_rdata[CFG_WIDE_BIT]              = wide_q;
                reg_rdata[CFG_TXLSB_BIT]             = txl_q;
                reg_rdata[CFG_RXLSB_BIT]             = rxl_q;
                reg_rdata[CFG_DIV_LO +: HALF_DIV_W]  = div_q;
            end
            ADDR_W'(OFF_RXD):    reg_rdata[MAX_BITS-1:0]     = din_q;
            ADDR_W'(OFF_CAUSE):  reg_rdata[0]                = cause_q;
            ADDR_W'(OFF_TIMING): reg_rdata[TIM_CODE_LO +: 2] = tim_code_q;
            default:             reg_rdata = '0;
        endcase
    end

    assign irq = cause_q;

    spi_tick_gen #(.DIV_W(HALF_DIV_W)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    spi_xfer_engine #(.MAX_BITS(MAX_BITS)) engine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_in   (cfg_live),
        .word_in  (reg_wdata[MAX_BITS-1:0]),
        .miso     (miso),
        .tick     (tick),
        .run      (run),
        .busy     (busy),
        .done     (xfer_done),
        .rx_word  (rx_word),
        .sck      (sck),
        .mosi     (mosi),
        .half_div (half_div)
    );

    spi_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) csdec_i (
        .en   (ctl_en_q),
        .sel  (ctl_sel_q),
        .cs_n (cs_n)
    );

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> cause_q);

    assert_cause_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && (reg_wdata == '0) && !xfer_done) |=> !cause_q);

endmodule

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sck, mosi;
    logic        miso = 1'b0;
    logic [7:0]  cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // scoreboard of expected transmit words
    int exp_q[$];

    // slave model state
    bit          sl_armed = 0;
    bit          sl_cpha, sl_txl, sl_rxl, sl_gap_bad;
    int          sl_n, sl_k, sl_j, sl_div, sl_last;
    logic [15:0] sl_a, sl_b, sl_obs;
    logic        sl_prev;
    int          cyc = 0;

    initial forever #4 clk = ~clk;

    spi_regmaster dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfgw(bit cpol, bit cpha, bit wide, bit txl, bit rxl, int div);
        return (32'(rxl) << 14) | (32'(txl) << 13) | (32'(cpha) << 12) |
               (32'(cpol) << 11) | (32'(wide) << 5) | 32'(div & 15);
    endfunction

    function automatic int bpos(bit lsb, int n, int j);
        return lsb ? j : n - 1 - j;
    endfunction

    task automatic arm(bit cpha, bit wide, bit txl, bit rxl, int div,
                       logic [15:0] tx, logic [15:0] a, logic [15:0] b);
        repeat (2) @(negedge clk);
        sl_n = wide ? 16 : 8;
        sl_cpha = cpha; sl_txl = txl; sl_rxl = rxl; sl_div = div;
        sl_a = a; sl_b = b; sl_obs = '0;
        sl_k = 0; sl_j = 0; sl_gap_bad = 0;
        sl_prev = sck;
        miso = cpha ? 1'b0 : a[bpos(rxl, sl_n, 0)];
        exp_q.push_back(wide ? int'(tx) : int'(tx[7:0]));
        sl_armed = 1;
    endtask

    // slave and monitor: reacts to SCK edges, compares transmitted words
    initial forever begin
        @(negedge clk);
        cyc++;
        if (sl_armed && (sck !== sl_prev)) begin
            sl_prev = sck;
            sl_k++;
            if (sl_k > 1 && (cyc - sl_last) != sl_div + 1) sl_gap_bad = 1;
            sl_last = cyc;
            if (sl_cpha ? (sl_k % 2 == 0) : (sl_k % 2 == 1)) begin
                if (sl_j < sl_n) begin
                    sl_obs[bpos(sl_txl, sl_n, sl_j)] = mosi;
                    miso = sl_b[bpos(sl_rxl, sl_n, sl_j)];
                end
                sl_j++;
            end else if (sl_j < sl_n) begin
                miso = sl_a[bpos(sl_rxl, sl_n, sl_j)];
            end
            if (sl_k == 2 * sl_n) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected transfer", 32'(sl_obs), 32'hFFFF_FFFF);
                end else begin
                    chk("R5 mosi word", 32'(sl_obs), 32'(exp_q.pop_front()));
                end
                chk("R3 edge spacing", 32'(sl_gap_bad), 32'd0);
            end
        end
    end

    task automatic wait_irq(string tag);
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " R7 irq after word"}, 32'(irq), 32'd1);
    endtask

    task automatic run_word(string tag, bit cpol, bit cpha, bit wide, bit txl, bit rxl,
                            int div, logic [15:0] tx, logic [15:0] a, logic [15:0] b,
                            logic [31:0] exp);
        logic [31:0] v;
        wr('h04, cfgw(cpol, cpha, wide, txl, rxl, div));
        arm(cpha, wide, txl, rxl, div, tx, a, b);
        wr('h08, 32'(tx));
        wait_irq(tag);
        rd('h10, v);
        chk({tag, " R7 cause set"}, v, 32'd1);
        rd('h0C, v);
        chk({tag, " R8 rx word"}, v, exp);
        chk({tag, " R3 edge count"}, 32'(sl_k), 32'(2 * sl_n));
        chk({tag, " R11 sck idle"}, 32'(sck), 32'(cpol));
        wr('h10, 32'd0);
        rd('h10, v);
        chk({tag, " R7 cause cleared"}, v, 32'd0);
        chk({tag, " R7 irq cleared"}, 32'(irq), 32'd0);
        sl_armed = 0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog R3 act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h10, v); chk("R1 cause", v, 32'd0);
        rd('h18, v); chk("R1 timing", v, 32'h40);
        rd('h04, v); chk("R1 config", v, 32'd0);
        chk("R1 cs_n", 32'(cs_n), 32'hFF);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);

        // R2 chip selects
        wr('h00, (32'd5 << 2) | 32'd1);
        chk("R2 cs 5", 32'(cs_n), 32'hDF);
        rd('h00, v); chk("R2 ctl readback", v, 32'h15);
        wr('h00, (32'd2 << 2));
        chk("R2 disabled", 32'(cs_n), 32'hFF);
        wr('h00, (32'd7 << 2) | 32'd1);
        chk("R2 cs 7", 32'(cs_n), 32'h7F);

        // R3 R4 R5 R6 across modes, widths and bit orders
        run_word("mode0 8b", 0, 0, 0, 0, 0, 2, 16'h00A5, 16'h003C, 16'h00C3, 32'h3C);
        run_word("mode3 16b R4 R6", 1, 1, 1, 1, 0, 1, 16'h1234, 16'hBEEF, 16'h4110, 32'hBEEF);
        run_word("mode1 8b R6", 0, 1, 0, 0, 1, 0, 16'h005A, 16'h000E, 16'h0070, 32'h0E);
        run_word("mode2 8b R5", 1, 0, 0, 1, 1, 3, 16'h0096, 16'h002D, 16'h00D2, 32'h2D);

        // R9 sample point codes
        wr('h18, 32'h80);
        rd('h18, v); chk("R9 timing readback", v, 32'h80);
        run_word("late mode3 R9", 1, 1, 0, 0, 0, 2, 16'h0033, 16'h0055, 16'h00AA, 32'hAA);
        run_word("late mode0 16b R9", 0, 0, 1, 0, 1, 0, 16'hC001, 16'h0F0F, 16'hF00F, 32'hF00F);
        wr('h18, 32'hC0);
        run_word("code3 R9", 1, 1, 0, 0, 0, 2, 16'h0033, 16'h0055, 16'h00AA, 32'h55);
        wr('h18, 32'h00);
        run_word("code0 R9", 0, 0, 0, 0, 0, 1, 16'h0071, 16'h0066, 16'h0099, 32'h66);
        wr('h18, 32'h40);

        // R7 nonzero write to cause ignored
        wr('h04, cfgw(0, 0, 0, 0, 0, 1));
        arm(0, 0, 0, 0, 1, 16'h00C8, 16'h0081, 16'h007E);
        wr('h08, 32'h00C8);
        wait_irq("R7 nz");
        wr('h10, 32'h5);
        rd('h10, v); chk("R7 nonzero write ignored", v, 32'd1);
        chk("R7 irq held", 32'(irq), 32'd1);
        wr('h10, 32'h0);
        chk("R7 irq clear", 32'(irq), 32'd0);
        sl_armed = 0;

        // R10 write during busy ignored
        wr('h04, cfgw(0, 0, 0, 0, 0, 3));
        arm(0, 0, 0, 0, 3, 16'h0011, 16'h00E4, 16'h001B);
        wr('h08, 32'h0011);
        repeat (5) @(negedge clk);
        wr('h08, 32'h00EE);
        wait_irq("R10");
        rd('h0C, v); chk("R10 rx of first word", v, 32'hE4);
        wr('h10, 32'h0);
        repeat (60) @(negedge clk);
        chk("R10 no extra edges", 32'(sl_k), 32'd16);
        chk("R10 no second completion", 32'(irq), 32'd0);
        chk("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        sl_armed = 0;

        // R11 idle level follows polarity
        wr('h04, cfgw(1, 0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        chk("R11 idle high", 32'(sck), 32'd1);
        wr('h04, cfgw(0, 0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        chk("R11 idle low", 32'(sck), 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule